// File: doc/BRIEF.md
# VGA Raster Timing Generator

This block turns a pixel clock into the timing of a 640x480 display refreshed 60 times a second. Two raster counters step through every clock of a line and every line of a frame, sync and porch intervals included. From these counts the block drives active-low horizontal and vertical sync, an active-low blank flag and the position of the visible pixel. Each line runs sync pulse, back porch, visible pixels, front porch. Each frame runs the same four phases, measured in lines.

The visible pixel position has its origin at the top-left corner. x grows to the right and y grows downward. The position stays at zero until the visible window opens. It then follows the raster and holds its last count until the next line or frame begins. While the window is open the block paints eight vertical colour bars. Everywhere else it forces the colour outputs to zero. A PLL supplies the pixel clock (about 25 MHz with the default timing), and a DAC after the block produces the analog signal.

Default timing, in clocks per line: 96 sync, 48 back porch, 640 visible and 16 front porch, for a line total of 800. In lines per frame: 2 sync, 33 back porch, 480 visible and 10 front porch, for a frame total of 525. All eight figures, the bar width and the colour depth are parameters.

Top module: `vga_raster_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `hpos` and `vpos` are cleared to 0. In the cycle that follows, `hsync_n`, `vsync_n`, `blank_n`, `pixel_x` and `pixel_y` are all 0.
- R2: `hpos` advances by one on every clock. It runs from 0 to H_TOTAL-1 and then returns to 0.
- R3: `vpos` changes only on the clock where `hpos` goes from H_TOTAL-1 to 0. On that clock it advances by one, and after V_TOTAL-1 it returns to 0.
- R4: `hsync_n` is 0 exactly while `hpos` < H_SYNC. `vsync_n` is 0 exactly while `vpos` < V_SYNC.
- R5: `blank_n` is 1 only when `hpos` lies in [H_SYNC+H_BACK, H_SYNC+H_BACK+H_ACTIVE) and `vpos` lies in [V_SYNC+V_BACK, V_SYNC+V_BACK+V_ACTIVE). In every sync and porch interval it is 0.
- R6: `pixel_x` is 0 while `hpos` < H_SYNC+H_BACK. Inside the visible window it equals `hpos`-(H_SYNC+H_BACK). From `hpos` = H_SYNC+H_BACK+H_ACTIVE to the end of the line it holds at H_ACTIVE.
- R7: `pixel_y` follows the rule of R6 applied to `vpos`, using V_SYNC+V_BACK and V_ACTIVE.
- R8: Whenever `blank_n` is 0, `red`, `green` and `blue` are all 0.
- R9: While `blank_n` is 1, the bar number is `pixel_x`/BAR_WIDTH. Bars 0 to 7 show, in order: white, yellow, cyan, green, magenta, red, blue, black. A lit channel is all ones and an unlit channel is all zeros.
- R10: A reset that arrives at any point of a frame restarts the raster at `hpos` = `vpos` = 0 in the next cycle. Counting then resumes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | High only during visible pixels |
| red | output | COLOR_W | Red level |
| green | output | COLOR_W | Green level |
| blue | output | COLOR_W | Blue level |
| pixel_x | output | $clog2(H_ACTIVE+1) | Visible column, held per R6 |
| pixel_y | output | $clog2(V_ACTIVE+1) | Visible row, held per R7 |
| hpos | output | $clog2(H_TOTAL) | Raw horizontal raster count |
| vpos | output | $clog2(V_TOTAL) | Raw vertical raster count |

## Verification
The hardest states to reach are the frame corner and the edges of the vertical window. At the frame corner both counters wrap on the same clock. The vertical edges come only once per frame, and with the default timing a frame is 420,000 clocks long. The bench therefore overrides the timing parameters with a small raster of 25 clocks by 13 lines. This lets many frame wraps, window edges and the holding phases of both coordinates fit into a short run. Resets are inserted at random points and at a directed point in mid-frame. These show that the raster restarts cleanly from any phase.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;

  // Visible coordinate along one axis: zero before the window opens,
  // offset from the window start inside it, held at span afterwards.
  function automatic int axis_coord(int pos, int lead, int span);
    if (pos < lead) return 0;
    if (pos - lead >= span) return span;
    return pos - lead;
  endfunction

  // Colour bar number for a visible column.
  function automatic int bar_index(int x, int width);
    return x / width;
  endfunction

endpackage

// File: rtl/vga_axis_counter.sv
module vga_axis_counter #(
  parameter int TOTAL = 800,
  parameter int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(TOTAL - 1);

  assign wrap = step && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (wrap) count <= '0;
    else if (step) count <= count + 1'b1;
  end

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (step && count == LAST) |=> (count == '0));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (rst)
    (step && count != LAST) |=> (count == $past(count) + 1'b1));

  assert_hold_without_step_R3: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count));

  assert_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    count <= LAST);
endmodule

// File: rtl/vga_axis_decode.sv
module vga_axis_decode
  import vga_raster_pkg::*;
#(
  parameter int SYNC   = 96,
  parameter int BACK   = 48,
  parameter int ACTIVE = 640,
  parameter int PW     = 10,
  parameter int CW     = 10
) (
  input  logic [PW-1:0] pos,
  output logic          sync_n,
  output logic          active,
  output logic [CW-1:0] coord
);
  localparam int LEAD = SYNC + BACK;

  always_comb begin
    sync_n = !(int'(pos) < SYNC);
    active = (int'(pos) >= LEAD) && (int'(pos) < LEAD + ACTIVE);
    coord  = CW'(axis_coord(int'(pos), LEAD, ACTIVE));
  end
endmodule

// File: rtl/vga_bar_pattern.sv
module vga_bar_pattern
  import vga_raster_pkg::*;
#(
  parameter int XW        = 10,
  parameter int BAR_WIDTH = 80,
  parameter int COLOR_W   = 8
) (
  input  logic               active,
  input  logic [XW-1:0]      px,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue
);
  localparam logic [COLOR_W-1:0] FULL = '1;

  logic [2:0] bar;

  always_comb begin
    bar   = 3'(bar_index(int'(px), BAR_WIDTH));
    red   = (active && !bar[1]) ? FULL : '0;
    green = (active && !bar[2]) ? FULL : '0;
    blue  = (active && !bar[0]) ? FULL : '0;
  end
endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen #(
  parameter int H_SYNC    = 96,
  parameter int H_BACK    = 48,
  parameter int H_ACTIVE  = 640,
  parameter int H_FRONT   = 16,
  parameter int V_SYNC    = 2,
  parameter int V_BACK    = 33,
  parameter int V_ACTIVE  = 480,
  parameter int V_FRONT   = 10,
  parameter int BAR_WIDTH = 80,
  parameter int COLOR_W   = 8,
  localparam int H_TOTAL  = H_SYNC + H_BACK + H_ACTIVE + H_FRONT,
  localparam int V_TOTAL  = V_SYNC + V_BACK + V_ACTIVE + V_FRONT,
  localparam int HPW      = $clog2(H_TOTAL),
  localparam int VPW      = $clog2(V_TOTAL),
  localparam int XW       = $clog2(H_ACTIVE + 1),
  localparam int YW       = $clog2(V_ACTIVE + 1)
) (
  input  logic               clk,
  input  logic               rst,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic               blank_n,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue,
  output logic [XW-1:0]      pixel_x,
  output logic [YW-1:0]      pixel_y,
  output logic [HPW-1:0]     hpos,
  output logic [VPW-1:0]     vpos
);
  // Named internal events for the assertions below.
  logic line_end;
  logic frame_end;
  logic h_visible;
  logic v_visible;

  vga_axis_counter #(.TOTAL(H_TOTAL), .W(HPW)) u_hcount (
    .clk(clk), .rst(rst), .step(1'b1), .count(hpos), .wrap(line_end)
  );

  vga_axis_counter #(.TOTAL(V_TOTAL), .W(VPW)) u_vcount (
    .clk(clk), .rst(rst), .step(line_end), .count(vpos), .wrap(frame_end)
  );

  vga_axis_decode #(.SYNC(H_SYNC), .BACK(H_BACK), .ACTIVE(H_ACTIVE),
                    .PW(HPW), .CW(XW)) u_hdecode (
    .pos(hpos), .sync_n(hsync_n), .active(h_visible), .coord(pixel_x)
  );

  vga_axis_decode #(.SYNC(V_SYNC), .BACK(V_BACK), .ACTIVE(V_ACTIVE),
                    .PW(VPW), .CW(YW)) u_vdecode (
    .pos(vpos), .sync_n(vsync_n), .active(v_visible), .coord(pixel_y)
  );

  assign blank_n = h_visible && v_visible;

  vga_bar_pattern #(.XW(XW), .BAR_WIDTH(BAR_WIDTH), .COLOR_W(COLOR_W)) u_bars (
    .active(blank_n), .px(pixel_x), .red(red), .green(green), .blue(blue)
  );

  assert_dark_when_blank_R8: assert property (@(posedge clk) disable iff (rst)
    !blank_n |-> (red == '0 && green == '0 && blue == '0));

  assert_sync_is_blank_R5: assert property (@(posedge clk) disable iff (rst)
    (!hsync_n || !vsync_n) |-> !blank_n);

  assert_frame_end_on_line_end_R3: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (hpos == HPW'(H_TOTAL - 1)));

  assert_column_steps_R6: assert property (@(posedge clk) disable iff (rst)
    (blank_n && pixel_x != XW'(H_ACTIVE - 1)) |=> (pixel_x == $past(pixel_x) + 1'b1));

  assert_row_steady_in_line_R7: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(pixel_y));
endmodule

// File: tb/vga_raster_gen_test.sv
module vga_raster_gen_test;
  localparam int HS = 4, HB = 3, HA = 16, HF = 2;
  localparam int VS = 2, VB = 3, VA = 6, VF = 2;
  localparam int BW = 2, CWID = 4;
  localparam int HT = HS + HB + HA + HF;
  localparam int VT = VS + VB + VA + VF;
  localparam int NCYC = 3000;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst;
  logic hsync_n, vsync_n, blank_n;
  logic [CWID-1:0] red, green, blue;
  logic [$clog2(HA+1)-1:0] pixel_x;
  logic [$clog2(VA+1)-1:0] pixel_y;
  logic [$clog2(HT)-1:0] hpos;
  logic [$clog2(VT)-1:0] vpos;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vga_raster_gen #(
    .H_SYNC(HS), .H_BACK(HB), .H_ACTIVE(HA), .H_FRONT(HF),
    .V_SYNC(VS), .V_BACK(VB), .V_ACTIVE(VA), .V_FRONT(VF),
    .BAR_WIDTH(BW), .COLOR_W(CWID)
  ) uut (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .blank_n(blank_n), .red(red), .green(green), .blue(blue),
    .pixel_x(pixel_x), .pixel_y(pixel_y), .hpos(hpos), .vpos(vpos)
  );

  function automatic int vis_pos(int raw, int first, int len);
    int last_plus = first + len;
    if (raw >= last_plus) return len;
    else if (raw >= first) return raw - first;
    else return 0;
  endfunction

  // Colour table per bar, bits ordered r,g,b.
  function automatic int bar_rgb(int bar);
    case (bar)
      0: return 3'b111;
      1: return 3'b110;
      2: return 3'b011;
      3: return 3'b010;
      4: return 3'b101;
      5: return 3'b100;
      6: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(int eh, int ev, bit after_rst);
    int ex, ey, full, rgb;
    bit vis;
    full = (1 << CWID) - 1;
    ex = vis_pos(eh, HS + HB, HA);
    ey = vis_pos(ev, VS + VB, VA);
    vis = (eh >= HS + HB) && (eh < HS + HB + HA) && (ev >= VS + VB) && (ev < VS + VB + VA);
    if (after_rst) begin
      check(hpos == 0 && vpos == 0, "R1/R10 raster cleared", int'(hpos), 0);
      check(!hsync_n && !vsync_n && !blank_n, "R1 sync low after reset",
            int'({hsync_n, vsync_n, blank_n}), 0);
      check(pixel_x == 0 && pixel_y == 0, "R1 coords zero after reset",
            int'(pixel_x), 0);
    end
    check(int'(hpos) == eh, "R2 hpos", int'(hpos), eh);
    check(int'(vpos) == ev, "R3 vpos", int'(vpos), ev);
    check(hsync_n == (eh >= HS), "R4 hsync_n", int'(hsync_n), int'(eh >= HS));
    check(vsync_n == (ev >= VS), "R4 vsync_n", int'(vsync_n), int'(ev >= VS));
    check(blank_n == vis, "R5 blank_n", int'(blank_n), int'(vis));
    check(int'(pixel_x) == ex, "R6 pixel_x", int'(pixel_x), ex);
    check(int'(pixel_y) == ey, "R7 pixel_y", int'(pixel_y), ey);
    if (!vis) begin
      check(red == 0 && green == 0 && blue == 0, "R8 rgb dark",
            int'({red, green, blue}), 0);
    end else begin
      rgb = bar_rgb(ex / BW);
      check(int'(red) == (rgb[2] ? full : 0), "R9 red", int'(red), rgb[2] ? full : 0);
      check(int'(green) == (rgb[1] ? full : 0), "R9 green", int'(green), rgb[1] ? full : 0);
      check(int'(blue) == (rgb[0] ? full : 0), "R9 blue", int'(blue), rgb[0] ? full : 0);
    end
  endtask

  initial begin
    int eh, ev;
    bit after_rst;
    bit next_rst;
    void'($urandom(32'd2718));
    rst = 1'b1;
    eh = 0;
    ev = 0;
    @(negedge clk);
    @(negedge clk);
    after_rst = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      check_all(eh, ev, after_rst);
      // Directed mid-frame reset (R10), then sparse random resets.
      next_rst = (cyc < 2) || (cyc == 777) || (cyc > 1000 && ($urandom % 450) == 0);
      rst = next_rst;
      if (next_rst) begin
        eh = 0;
        ev = 0;
      end else if (eh == HT - 1) begin
        eh = 0;
        ev = (ev == VT - 1) ? 0 : ev + 1;
      end else begin
        eh = eh + 1;
      end
      after_rst = next_rst;
      @(negedge clk);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(LIMIT * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule